// File: doc/BRIEF.md
# SDRAM Burst Column Sequencer

This block turns one burst request into the stream of column addresses an SDRAM controller presents during a read or write burst. A one-clock start pulse carries the 10-bit start column, a 3-bit burst-length code in the mode-register encoding and a select between linear (sequential) and interleaved ordering. From the clock edge that samples the start, the block shows one column address per clock, together with valid, first-beat and last-beat flags, all from registers.

Fixed-length bursts of 1, 2, 4 or 8 beats wrap inside an aligned block of that size, so the column bits above the block stay constant. A full-page burst walks through the whole 1024-column row, wraps from 1023 to 0 and carries on until a stop request ends it. A stop request ends any burst early, and a new start pulse may be issued on any clock: it drops whatever burst is running and begins the new one at once. Command generation, the data path and refresh are handled elsewhere.

Top module: `bcs_top`

## Requirements
- R1: While the synchronous reset is high, and on the first clock after it is released with no start, `col_o` is 0 and `valid_o`, `first_o` and `last_o` are low.
- R2: A clock edge that samples `start_i` high makes that edge's outputs show beat 0: `col_o` equal to the sampled start column, `valid_o` and `first_o` high. This holds whether or not a burst was running and whether or not `stop_i` is also high; start takes priority and aborts the running burst.
- R3: The length code decodes as 000 to 1 beat, 001 to 2, 010 to 4, 011 to 8 and 111 to full page; the codes 100, 101 and 110 give a 1-beat burst.
- R4: In sequential order with a fixed length N of 2, 4 or 8, beat k shows the start column with its low log2(N) bits replaced by (start + k) mod N.
- R5: In interleaved order with a fixed length N, beat k shows the start column with its low log2(N) bits replaced by the start's low bits XOR k.
- R6: A full-page burst shows (start + k) mod 1024 on beat k, ignores the interleave select, never raises `last_o`, and keeps running until a stop.
- R7: For a fixed length N, `last_o` is high on beat N-1 only, and `valid_o` goes low on the clock after that beat unless a new start arrives.
- R8: `stop_i` sampled high while a beat is shown (and `start_i` low) makes the next clock show no valid beat; `stop_i` while idle has no effect.
- R9: `first_o` is high only on beat 0 of a burst; `first_o` and `last_o` are never high without `valid_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Begin a burst on this edge |
| start_col_i | input | 10 | Column of beat 0 |
| len_code_i | input | 3 | Burst-length code |
| interleave_i | input | 1 | 1 selects interleaved order |
| stop_i | input | 1 | End the running burst |
| col_o | output | 10 | Column address of the current beat |
| valid_o | output | 1 | A beat is shown this cycle |
| first_o | output | 1 | Current beat is beat 0 |
| last_o | output | 1 | Current beat is the final beat of a fixed-length burst |

## Verification
Bursts are run with every length code, including the three unused ones, in both orders and with start columns whose low bits are non-zero, so that a wrong wrap point, a carry leaking into the upper bits, or swapped sequential and interleaved rules give a different address. Full-page runs starting near column 1023 and running past 1024 beats tell a correct row wrap from a saturating or block-limited counter, and show that the interleave select is ignored there. Stops at random beats, stops while idle and starts that land on a running burst (with stop also high) separate the priority of start over stop and over natural burst end. Random start columns, codes and stop points mixed with these directed cases cover the combinations.

// File: rtl/bcs_pkg.sv
package bcs_pkg;

  localparam int CODE_W = 3;

  typedef enum logic [CODE_W-1:0] {
    BLC_ONE   = 3'b000,
    BLC_TWO   = 3'b001,
    BLC_FOUR  = 3'b010,
    BLC_EIGHT = 3'b011,
    BLC_PAGE  = 3'b111
  } bl_code_e;

endpackage

// File: rtl/bcs_len_decode.sv
// Burst-length code to wrap mask. Mask holds N-1 for fixed lengths,
// all ones for a full page (whole row).
module bcs_len_decode
  import bcs_pkg::*;
#(
  parameter int COL_W     = 10,
  parameter int MAX_LOG2  = 3
) (
  input  logic [CODE_W-1:0] code_i,
  output logic [COL_W-1:0]  mask_o,
  output logic              full_o
);

  localparam int NUM_FIXED = MAX_LOG2 + 1;

  logic [COL_W-1:0] fixed_mask [NUM_FIXED];

  genvar g;
  generate
    for (g = 0; g < NUM_FIXED; g++) begin : g_mask
      assign fixed_mask[g] = COL_W'((1 << g) - 1);
    end
  endgenerate

  always_comb begin
    full_o = 1'b0;
    mask_o = fixed_mask[0];
    case (code_i)
      BLC_TWO:   mask_o = fixed_mask[1];
      BLC_FOUR:  mask_o = fixed_mask[2];
      BLC_EIGHT: mask_o = fixed_mask[MAX_LOG2];
      BLC_PAGE: begin
        mask_o = '1;
        full_o = 1'b1;
      end
      default:   mask_o = fixed_mask[0];
    endcase
  end

endmodule

// File: rtl/bcs_addr_gen.sv
// Column for a given beat: bits under the mask come from the ordering rule,
// bits above it are taken from the base column unchanged.
module bcs_addr_gen #(
  parameter int COL_W = 10
) (
  input  logic [COL_W-1:0] base_i,
  input  logic [COL_W-1:0] beat_i,
  input  logic [COL_W-1:0] mask_i,
  input  logic             ilv_i,
  output logic [COL_W-1:0] addr_o
);

  logic [COL_W-1:0] lin_sum;
  logic [COL_W-1:0] xor_val;

  assign lin_sum = base_i + beat_i;
  assign xor_val = base_i ^ beat_i;

  genvar b;
  generate
    for (b = 0; b < COL_W; b++) begin : g_bit
      always_comb begin
        if (!mask_i[b])
          addr_o[b] = base_i[b];
        else if (ilv_i)
          addr_o[b] = xor_val[b];
        else
          addr_o[b] = lin_sum[b];
      end
    end
  endgenerate

endmodule

// File: rtl/bcs_ctrl.sv
// Burst state and registered outputs.
module bcs_ctrl #(
  parameter int COL_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic [COL_W-1:0] start_col_i,
  input  logic [COL_W-1:0] dec_mask_i,
  input  logic             dec_full_i,
  input  logic             ilv_i,
  input  logic             stop_i,
  output logic [COL_W-1:0] gen_base_o,
  output logic [COL_W-1:0] gen_beat_o,
  output logic [COL_W-1:0] gen_mask_o,
  output logic             gen_ilv_o,
  input  logic [COL_W-1:0] gen_addr_i,
  output logic [COL_W-1:0] col_o,
  output logic             valid_o,
  output logic             first_o,
  output logic             last_o
);

  logic [COL_W-1:0] base_q;
  logic [COL_W-1:0] beat_q;
  logic [COL_W-1:0] mask_q;
  logic             ilv_q;
  logic             full_q;

  logic             sel_full;
  logic             nxt_last;
  logic             advance;

  always_comb begin
    if (start_i) begin
      gen_base_o = start_col_i;
      gen_beat_o = '0;
      gen_mask_o = dec_mask_i;
      gen_ilv_o  = ilv_i & ~dec_full_i;
      sel_full   = dec_full_i;
    end else begin
      gen_base_o = base_q;
      gen_beat_o = beat_q + COL_W'(1);
      gen_mask_o = mask_q;
      gen_ilv_o  = ilv_q;
      sel_full   = full_q;
    end
    nxt_last = !sel_full && (gen_beat_o == gen_mask_o);
    advance  = valid_o && !last_o && !stop_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q  <= '0;
      beat_q  <= '0;
      mask_q  <= '0;
      ilv_q   <= 1'b0;
      full_q  <= 1'b0;
      col_o   <= '0;
      valid_o <= 1'b0;
      first_o <= 1'b0;
      last_o  <= 1'b0;
    end else if (start_i) begin
      base_q  <= start_col_i;
      beat_q  <= '0;
      mask_q  <= dec_mask_i;
      ilv_q   <= ilv_i & ~dec_full_i;
      full_q  <= dec_full_i;
      col_o   <= gen_addr_i;
      valid_o <= 1'b1;
      first_o <= 1'b1;
      last_o  <= nxt_last;
    end else if (advance) begin
      beat_q  <= gen_beat_o;
      col_o   <= gen_addr_i;
      first_o <= 1'b0;
      last_o  <= nxt_last;
    end else begin
      valid_o <= 1'b0;
      first_o <= 1'b0;
      last_o  <= 1'b0;
    end
  end

endmodule

// File: rtl/bcs_top.sv
module bcs_top
  import bcs_pkg::*;
#(
  parameter int COL_W    = 10,
  parameter int MAX_LOG2 = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [COL_W-1:0]  start_col_i,
  input  logic [CODE_W-1:0] len_code_i,
  input  logic              interleave_i,
  input  logic              stop_i,
  output logic [COL_W-1:0]  col_o,
  output logic              valid_o,
  output logic              first_o,
  output logic              last_o
);

  logic [COL_W-1:0] dec_mask;
  logic             dec_full;
  logic [COL_W-1:0] gen_base;
  logic [COL_W-1:0] gen_beat;
  logic [COL_W-1:0] gen_mask;
  logic             gen_ilv;
  logic [COL_W-1:0] gen_addr;

  bcs_len_decode #(.COL_W(COL_W), .MAX_LOG2(MAX_LOG2)) i_dec (
    .code_i (len_code_i),
    .mask_o (dec_mask),
    .full_o (dec_full)
  );

  bcs_addr_gen #(.COL_W(COL_W)) i_gen (
    .base_i (gen_base),
    .beat_i (gen_beat),
    .mask_i (gen_mask),
    .ilv_i  (gen_ilv),
    .addr_o (gen_addr)
  );

  bcs_ctrl #(.COL_W(COL_W)) i_ctrl (
    .clk         (clk),
    .rst         (rst),
    .start_i     (start_i),
    .start_col_i (start_col_i),
    .dec_mask_i  (dec_mask),
    .dec_full_i  (dec_full),
    .ilv_i       (interleave_i),
    .stop_i      (stop_i),
    .gen_base_o  (gen_base),
    .gen_beat_o  (gen_beat),
    .gen_mask_o  (gen_mask),
    .gen_ilv_o   (gen_ilv),
    .gen_addr_i  (gen_addr),
    .col_o       (col_o),
    .valid_o     (valid_o),
    .first_o     (first_o),
    .last_o      (last_o)
  );

endmodule

// File: rtl/bcs_chk.sv
module bcs_chk #(
  parameter int COL_W = 10
) (
  input logic             clk,
  input logic             rst,
  input logic             start_i,
  input logic [COL_W-1:0] start_col_i,
  input logic [2:0]       len_code_i,
  input logic             stop_i,
  input logic [COL_W-1:0] col_o,
  input logic             valid_o,
  input logic             first_o,
  input logic             last_o
);

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    rst |=> (!valid_o && !first_o && !last_o && col_o == '0));

  // R2
  start_beat0_chk: assert property (@(posedge clk) disable iff (rst)
    start_i |=> (valid_o && first_o && col_o == $past(start_col_i)));

  // R6
  page_no_last_chk: assert property (@(posedge clk) disable iff (rst)
    (start_i && len_code_i == 3'b111) |=> !last_o);

  // R7
  end_after_last_chk: assert property (@(posedge clk) disable iff (rst)
    (valid_o && last_o && !start_i) |=> !valid_o);

  // R8
  stop_ends_chk: assert property (@(posedge clk) disable iff (rst)
    (valid_o && stop_i && !start_i) |=> !valid_o);

  // R9
  flags_need_valid_chk: assert property (@(posedge clk) disable iff (rst)
    (first_o || last_o) |-> valid_o);

  // R9
  first_once_chk: assert property (@(posedge clk) disable iff (rst)
    (valid_o && !last_o && !stop_i && !start_i) |=> (valid_o && !first_o));

endmodule

bind bcs_top bcs_chk #(.COL_W(COL_W)) i_bcs_chk (
  .clk         (clk),
  .rst         (rst),
  .start_i     (start_i),
  .start_col_i (start_col_i),
  .len_code_i  (len_code_i),
  .stop_i      (stop_i),
  .col_o       (col_o),
  .valid_o     (valid_o),
  .first_o     (first_o),
  .last_o      (last_o)
);

// File: tb/test_bcs_top.sv
`timescale 1ns/1ps
module test_bcs_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start_i = 1'b0;
  logic [9:0] start_col_i = '0;
  logic [2:0] len_code_i = '0;
  logic       interleave_i = 1'b0;
  logic       stop_i = 1'b0;
  logic [9:0] col_o;
  logic       valid_o, first_o, last_o;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  bcs_top i_bcs_top (
    .clk(clk), .rst(rst), .start_i(start_i), .start_col_i(start_col_i),
    .len_code_i(len_code_i), .interleave_i(interleave_i), .stop_i(stop_i),
    .col_o(col_o), .valid_o(valid_o), .first_o(first_o), .last_o(last_o)
  );

  // R3: beats per code, 0 means full page
  function automatic int beats_of(input logic [2:0] code);
    case (code)
      3'b001:  return 2;
      3'b010:  return 4;
      3'b011:  return 8;
      3'b111:  return 0;
      default: return 1;
    endcase
  endfunction

  // R4 R5 R6: expected column on beat k
  function automatic logic [9:0] exp_col(input logic [9:0] sc, input logic [2:0] code,
                                         input bit ilv, input int k);
    int n;
    int lo;
    n = beats_of(code);
    if (n == 0) return 10'((int'(sc) + k) % 1024);
    if (ilv) lo = (int'(sc) % n) ^ k;
    else     lo = (int'(sc) + k) % n;
    return 10'((int'(sc) / n) * n + lo);
  endfunction

  task automatic check(input string req, input bit ok, input string act, input string exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%s expected=%s", req, act, exp);
    end
  endtask

  task automatic check_idle(input string req);
    check(req, !valid_o && !first_o && !last_o,
          $sformatf("v%0b f%0b l%0b", valid_o, first_o, last_o), "v0 f0 l0");
  endtask

  // drive a start at the current (negedge) time
  task automatic issue(input logic [9:0] sc, input logic [2:0] code, input bit ilv, input bit stp);
    start_i = 1'b1; start_col_i = sc; len_code_i = code; interleave_i = ilv; stop_i = stp;
  endtask

  // follow a burst issued just before; stop_at < 0 means no early stop
  task automatic follow(input logic [9:0] sc, input logic [2:0] code, input bit ilv,
                        input int stop_at, input int page_beats);
    int n;
    bit full;
    logic [9:0] e;
    bit el;
    full = (beats_of(code) == 0);
    n = full ? page_beats : beats_of(code);
    @(negedge clk);
    start_i = 1'b0; stop_i = 1'b0;
    for (int k = 0; k < n; k++) begin
      e  = exp_col(sc, code, ilv, k);
      el = !full && (k == n - 1);
      check(full ? "R6" : (ilv ? "R5" : "R4"),
            valid_o && col_o == e && first_o == (k == 0) && last_o == el,
            $sformatf("v%0b col%0d f%0b l%0b", valid_o, col_o, first_o, last_o),
            $sformatf("v1 col%0d f%0b l%0b k%0d code%0d", e, k == 0, el, k, code));
      if (k == stop_at || (full && k == n - 1)) begin
        stop_i = 1'b1;
        @(negedge clk);
        stop_i = 1'b0;
        check_idle("R8");
        return;
      end
      @(negedge clk);
    end
    check_idle("R7");
  endtask

  initial begin
    while (!done) begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        failures++;
        $display("FAIL watchdog actual=%0d expected<150000", cycles);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check("R1", !valid_o && !first_o && !last_o && col_o == 10'd0,
          $sformatf("v%0b col%0d", valid_o, col_o), "v0 col0");
    rst = 1'b0;
    @(negedge clk);
    check("R1", !valid_o && col_o == 10'd0, $sformatf("v%0b col%0d", valid_o, col_o), "v0 col0");

    // R8: stop while idle has no effect
    stop_i = 1'b1; @(negedge clk); stop_i = 1'b0;
    check_idle("R8");

    // R3: every code, both orders
    for (int c = 0; c < 8; c++) begin
      if (c == 7) continue;
      issue(10'd437, 3'(c), 1'b0, 1'b0); follow(10'd437, 3'(c), 1'b0, -1, 0);
      issue(10'd437, 3'(c), 1'b1, 1'b0); follow(10'd437, 3'(c), 1'b1, -1, 0);
    end

    // R6: row wrap, interleave ignored, past one full row
    issue(10'd1020, 3'b111, 1'b0, 1'b0); follow(10'd1020, 3'b111, 1'b0, -1, 10);
    issue(10'd1021, 3'b111, 1'b1, 1'b0); follow(10'd1021, 3'b111, 1'b1, -1, 1030);

    // R8: early stop on fixed length
    issue(10'd5, 3'b011, 1'b1, 1'b0); follow(10'd5, 3'b011, 1'b1, 2, 0);
    issue(10'd6, 3'b011, 1'b0, 1'b0); follow(10'd6, 3'b011, 1'b0, 0, 0);

    // R2: new start aborts running burst, wins over stop
    issue(10'd100, 3'b011, 1'b0, 1'b0);
    @(negedge clk); start_i = 1'b0;
    @(negedge clk);
    issue(10'd777, 3'b010, 1'b1, 1'b1);
    @(negedge clk);
    check("R2", valid_o && first_o && col_o == 10'd777,
          $sformatf("v%0b f%0b col%0d", valid_o, first_o, col_o), "v1 f1 col777");
    start_i = 1'b0; stop_i = 1'b0;
    @(negedge clk);
    check("R2", valid_o && !first_o && col_o == exp_col(10'd777, 3'b010, 1'b1, 1),
          $sformatf("v%0b col%0d", valid_o, col_o),
          $sformatf("v1 col%0d", exp_col(10'd777, 3'b010, 1'b1, 1)));

    // R2: back-to-back starts, last beat into new start
    issue(10'd9, 3'b000, 1'b0, 1'b0);
    @(negedge clk);
    issue(10'd300, 3'b001, 1'b0, 1'b0);
    check("R2", valid_o && last_o && col_o == 10'd9,
          $sformatf("v%0b l%0b col%0d", valid_o, last_o, col_o), "v1 l1 col9");
    follow(10'd300, 3'b001, 1'b0, -1, 0);

    // random mix
    for (int i = 0; i < 80; i++) begin
      logic [9:0] sc;
      logic [2:0] code;
      bit ilv;
      int sa;
      int pb;
      sc   = 10'($urandom);
      code = 3'($urandom);
      ilv  = 1'($urandom);
      pb   = 1 + int'($urandom % 40);
      sa   = ($urandom % 3 == 0) ? int'($urandom % 8) : -1;
      issue(sc, code, ilv, 1'b0);
      follow(sc, code, ilv, sa, pb);
      if ($urandom % 2 == 1) @(negedge clk);
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule